// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer and Event Counter

This block is an 8-bit up-counter with a preload register and a control register, reached through a small register port. The port has one write path and one combinational read path. A select bit picks between two locations: the counter/preload location and the control location. The counter climbs toward its all-ones value. The step after all-ones reloads it from the preload register and raises an overflow pulse. When enabled, it also raises an interrupt request in the same cycle.

Three sources can drive the count:
- Rising edges of an external pin, after a two-flop synchroniser.
- An internal tick passed through a selectable power-of-two prescaler.
- The same prescaled tick, gated by a pulse-width measurement. The measurement arms on a pin edge of selectable polarity. It counts until the pin returns to its starting level, then clears its own run bit. This makes it a one-shot measurement.

A write to the counter location loads the counter only while the run bit is clear. While the block is running, the write updates only the preload value. A read of the counter location freezes counting for that cycle.

Top module: `ptmr_unit`

## Requirements
- R1: After reset the counter, preload and control registers read 0, and `ovf_pulse` and `irq_flag` are low.
- R2: Select 0 addresses the counter/preload location and select 1 the control location. The control byte layout is:
  - mode in bits [7:6]: 00 event, 01 timer, 10 pulse-width, 11 halt
  - run bit in bit 4
  - edge select in bit 3, where 1 means rising
  - prescale stage n in bits [2:0]
  - bit 5, which always reads 0
- R3: Each count tick adds 1 to the counter. The tick taken at FFh reloads the preload value instead. `ovf_pulse` is high for exactly one cycle, in the cycle in which the counter first shows the reloaded value.
- R4: `irq_flag` pulses together with `ovf_pulse` when `irq_en` was high in the overflow cycle. It stays low whenever `irq_en` was low.
- R5: In timer mode, a free-running prescaler counts every `tick_raw` from reset. A `tick_raw` counts when the low n bits of that prescaler are all ones, so there is one count per 2^n raw ticks.
- R6: In event mode, every rising edge of `ext_pin` counts once, without the prescaler.
- R7: While the run bit is 0, a write to the counter location loads both the preload register and the counter.
- R8: While the run bit is 1, a write to the counter location changes only the preload register. The counter keeps its value.
- R9: A count tick that arrives in a cycle with a read of the counter location is lost.
- R10: In pulse-width mode with run set and n=0, the counter advances by the width of the pin pulse in clock cycles. The measured pulse is high when edge select is 1 and low when it is 0.
- R11: When a measurement ends, the run bit clears. Further pulses leave the result unchanged until run is written to 1 again.
- R12: Overflow during a measurement reloads from preload and raises `ovf_pulse`/`irq_flag`, as in the other modes.
- R13: In halt mode, or with run clear, no tick or pin edge changes the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write location: 0 counter/preload, 1 control |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | Read location: 0 counter, 1 control |
| rd_data | output | 8 | Read data, combinational |
| ext_pin | input | 1 | External event / measurement input |
| tick_raw | input | 1 | Raw internal clock enable |
| irq_en | input | 1 | Timer interrupt enable |
| irq_flag | output | 1 | Overflow interrupt request, one cycle |
| ovf_pulse | output | 1 | Overflow pulse, one cycle |

## Verification
Some rules are checked by assertions on every cycle:
- the counter reloads from preload right after an overflow step;
- a masked interrupt never raises `irq_flag`;
- a counter read, a running write and halt mode each leave the counter unchanged;
- the end of a measurement clears the run bit.

Other behaviour can only be shown by the bench's scenarios:
- the prescaler ratio and its free-running phase;
- the number of counts per pin edge through the synchroniser;
- that a measured width equals the pulse length for either polarity;
- that a finished measurement stays put through later pulses.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
package ptmr_pkg;
  typedef enum logic [1:0] {
    MODE_EVENT = 2'b00,
    MODE_TIMER = 2'b01,
    MODE_PULSE = 2'b10,
    MODE_HALT  = 2'b11
  } tmr_mode_e;

  // control byte: mode[7:6], zero[5], run[4], edge_rise[3], presc[2:0]
  typedef struct packed {
    tmr_mode_e  mode;
    logic       zero;
    logic       run;
    logic       edge_rise;
    logic [2:0] presc;
  } tmr_ctrl_t;

  localparam int CTRL_W = 8;
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'hDF;
endpackage

// File: rtl/ptmr_prescaler.sv
`timescale 1ns/1ps
module ptmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_raw,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_out
);
  localparam int PCNT_W = (1 << SEL_W) - 1;

  logic [PCNT_W-1:0] pcnt;

  // a stage fires when its low 'sel' bits are all ones
  function automatic logic stage_hit(input logic [PCNT_W-1:0] c,
                                     input logic [SEL_W-1:0]  s);
    logic [PCNT_W-1:0] mask;
    mask = ~({PCNT_W{1'b1}} << s);
    return (c & mask) == mask;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= '0;
    else if (tick_raw) pcnt <= pcnt + 1'b1;
  end

  assign tick_out = tick_raw && stage_hit(pcnt, sel);
endmodule

// File: rtl/ptmr_pin_sync.sv
`timescale 1ns/1ps
module ptmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] shr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shr <= '0;
    else        shr <= {shr[STAGES-1:0], pin};
  end

  assign rise =  shr[STAGES-1] && !shr[STAGES];
  assign fall = !shr[STAGES-1] &&  shr[STAGES];
endmodule

// File: rtl/ptmr_pulse_meas.sv
`timescale 1ns/1ps
module ptmr_pulse_meas (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic edge_rise,
  input  logic rise,
  input  logic fall,
  output logic measuring,
  output logic done
);
  logic start_edge, stop_edge;

  assign start_edge = edge_rise ? rise : fall;
  assign stop_edge  = edge_rise ? fall : rise;
  assign done       = arm && measuring && stop_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      measuring <= 1'b0;
    else if (!arm)                   measuring <= 1'b0;
    else if (!measuring && start_edge) measuring <= 1'b1;
    else if (done)                   measuring <= 1'b0;
  end

  // R11
  meas_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !measuring);
endmodule

// File: rtl/ptmr_unit.sv
`timescale 1ns/1ps
module ptmr_unit #(
  parameter int CNT_W       = 8,
  parameter int PS_SEL_W    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data,
  input  logic             ext_pin,
  input  logic             tick_raw,
  input  logic             irq_en,
  output logic             irq_flag,
  output logic             ovf_pulse
);
  import ptmr_pkg::*;

  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] cnt, preload;
  logic             cnt_wr, ctl_wr, freeze;
  logic             ptick, pin_rise, pin_fall, measuring, meas_done;
  logic             src_tick, step, ovf_evt, arm;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] p);
    return (c == {CNT_W{1'b1}}) ? p : c + 1'b1;
  endfunction

  assign cnt_wr = wr_en && !wr_sel;
  assign ctl_wr = wr_en &&  wr_sel;
  assign freeze = rd_en && !rd_sel;
  assign arm    = ctrl.run && (ctrl.mode == MODE_PULSE);

  ptmr_prescaler #(.SEL_W(PS_SEL_W)) i_presc (
    .clk(clk), .rst_n(rst_n), .tick_raw(tick_raw),
    .sel(ctrl.presc[PS_SEL_W-1:0]), .tick_out(ptick));

  ptmr_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(pin_rise), .fall(pin_fall));

  ptmr_pulse_meas i_meas (
    .clk(clk), .rst_n(rst_n), .arm(arm), .edge_rise(ctrl.edge_rise),
    .rise(pin_rise), .fall(pin_fall), .measuring(measuring), .done(meas_done));

  always_comb begin
    unique case (ctrl.mode)
      MODE_EVENT: src_tick = pin_rise;
      MODE_TIMER: src_tick = ptick;
      MODE_PULSE: src_tick = ptick && measuring;
      default:    src_tick = 1'b0;
    endcase
  end

  assign step    = ctrl.run && !freeze && src_tick;
  assign ovf_evt = step && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      preload <= '0;
    end else begin
      if (cnt_wr) preload <= wr_data;
      if (cnt_wr && !ctrl.run) cnt <= wr_data;
      else if (step)           cnt <= next_count(cnt, preload);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl     <= tmr_ctrl_t'('0);
    else if (ctl_wr)    ctrl     <= tmr_ctrl_t'(wr_data[CTRL_W-1:0] & CTRL_WMASK);
    else if (meas_done) ctrl.run <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_pulse <= 1'b0;
      irq_flag  <= 1'b0;
    end else begin
      ovf_pulse <= ovf_evt;
      irq_flag  <= ovf_evt && irq_en;
    end
  end

  assign rd_data = rd_sel ? CNT_W'(ctrl) : cnt;

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == $past(preload)) && ovf_pulse);
  // R4
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_flag);
  // R9
  read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cnt_wr) |=> $stable(cnt));
  // R8
  run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && ctrl.run && !step) |=> $stable(cnt));
  // R11
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && !ctl_wr) |=> !ctrl.run);
  // R13
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl.mode == MODE_HALT) && !cnt_wr) |=> $stable(cnt));
endmodule

// File: tb/test_ptmr_unit.sv
`timescale 1ns/1ps
module test_ptmr_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ext_pin = 1'b0, tick_raw = 1'b0, irq_en = 1'b1;
  logic       irq_flag, ovf_pulse;

  int total = 0, fails = 0, ovf_seen = 0, irq_seen = 0;

  always #10 clk = ~clk;

  ptmr_unit i_ptmr_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .ext_pin(ext_pin),
    .tick_raw(tick_raw), .irq_en(irq_en), .irq_flag(irq_flag), .ovf_pulse(ovf_pulse));

  always @(negedge clk) begin
    if (ovf_pulse) ovf_seen++;
    if (irq_flag)  irq_seen++;
  end

  // timer-mode vectors; every tick count is a multiple of 128 so the prescaler phase is 0
  typedef struct packed {
    logic [7:0]  start;
    logic [7:0]  pre;
    logic [2:0]  ps;
    logic [15:0] nticks;
    logic [7:0]  exp_cnt;
    logic [7:0]  exp_ovf;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'hF0, 8'hF0, 3'd0, 16'd128, 8'hF0, 8'd8},
    '{8'h00, 8'h80, 3'd1, 16'd128, 8'h40, 8'd0},
    '{8'hFE, 8'h00, 3'd2, 16'd256, 8'h3E, 8'd1},
    '{8'hE0, 8'hFC, 3'd3, 16'd256, 8'hFC, 8'd1},
    '{8'h00, 8'h00, 3'd7, 16'd384, 8'h03, 8'd0},
    '{8'hFF, 8'hFC, 3'd0, 16'd128, 8'hFF, 8'd32}
  };

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(negedge clk);
    rd_sel = sel; rd_en = 1'b1;
    #1 v = rd_data;
    #1 rd_en = 1'b0;
  endtask

  task automatic pin_pulse(input logic lvl, input int width);
    @(negedge clk);
    ext_pin = lvl;
    repeat (width) @(negedge clk);
    ext_pin = ~lvl;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int o0, i0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1'b0, v); check("R1 counter", v, 0);
    rd(1'b1, v); check("R1 control", v, 0);
    check("R1 ovf_pulse", ovf_pulse, 0);
    check("R1 irq_flag", irq_flag, 0);

    // R5 timer prescaling, R3/R4 overflow, R7/R8 writes
    foreach (VECS[k]) begin
      tick_raw = 1'b0;
      wr(1'b1, 8'h40 | 8'(VECS[k].ps));
      wr(1'b0, VECS[k].start);
      rd(1'b0, v); check("R7 stopped write loads counter", v, VECS[k].start);
      wr(1'b1, 8'h50 | 8'(VECS[k].ps));
      wr(1'b0, VECS[k].pre);
      rd(1'b0, v); check("R8 running write keeps counter", v, VECS[k].start);
      o0 = ovf_seen; i0 = irq_seen;
      @(negedge clk); tick_raw = 1'b1;
      repeat (int'(VECS[k].nticks)) @(negedge clk);
      tick_raw = 1'b0;
      repeat (3) @(negedge clk);
      rd(1'b0, v); check("R5 timer count", v, VECS[k].exp_cnt);
      check("R3 overflow count", ovf_seen - o0, int'(VECS[k].exp_ovf));
      check("R4 irq count", irq_seen - i0, int'(VECS[k].exp_ovf));
    end
    rd(1'b1, v); check("R2 control readback", v, 8'h50);
    wr(1'b1, 8'hFF);
    rd(1'b1, v); check("R2 bit5 reads zero", v, 8'hDF);

    // R6 event mode: FD, preload FD, five rising edges
    wr(1'b1, 8'h00); wr(1'b0, 8'hFD); wr(1'b1, 8'h10);
    o0 = ovf_seen; i0 = irq_seen;
    for (int p = 0; p < 5; p++) begin pin_pulse(1'b1, 3); repeat (3) @(negedge clk); end
    repeat (5) @(negedge clk);
    rd(1'b0, v); check("R6 event count", v, 8'hFF);
    check("R6 event overflow", ovf_seen - o0, 1);
    check("R4 irq in event mode", irq_seen - i0, 1);

    // R4 masked interrupt
    irq_en = 1'b0;
    wr(1'b1, 8'h40); wr(1'b0, 8'hFE); wr(1'b1, 8'h50);
    o0 = ovf_seen; i0 = irq_seen;
    @(negedge clk); tick_raw = 1'b1; repeat (4) @(negedge clk); tick_raw = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 masked ovf_pulse", ovf_seen - o0, 2);
    check("R4 masked irq", irq_seen - i0, 0);
    irq_en = 1'b1;

    // R9 read freeze: 10 ticks, 3 of them under a counter read
    wr(1'b1, 8'h40); wr(1'b0, 8'h10); wr(1'b1, 8'h50);
    @(negedge clk); tick_raw = 1'b1;
    repeat (3) @(negedge clk); rd_sel = 1'b0; rd_en = 1'b1;
    repeat (3) @(negedge clk); rd_en = 1'b0;
    repeat (4) @(negedge clk); tick_raw = 1'b0;
    repeat (2) @(negedge clk);
    rd(1'b0, v); check("R9 read freeze", v, 8'h17);

    // R13 halt mode and run clear
    wr(1'b1, 8'hC0); wr(1'b0, 8'h33); wr(1'b1, 8'hD0);
    @(negedge clk); tick_raw = 1'b1;
    pin_pulse(1'b1, 4); repeat (10) @(negedge clk); tick_raw = 1'b0;
    rd(1'b0, v); check("R13 halt mode", v, 8'h33);
    wr(1'b1, 8'h40);
    @(negedge clk); tick_raw = 1'b1; repeat (10) @(negedge clk); tick_raw = 1'b0;
    rd(1'b0, v); check("R13 run clear", v, 8'h33);

    // R10 pulse-width, rising polarity
    wr(1'b1, 8'h88); wr(1'b0, 8'h00); wr(1'b1, 8'h98);
    @(negedge clk); tick_raw = 1'b1;
    pin_pulse(1'b1, 12); repeat (6) @(negedge clk);
    rd(1'b0, v); check("R10 high width", v, 8'h0C);
    rd(1'b1, v); check("R11 run auto clear", v, 8'h88);
    pin_pulse(1'b1, 5); repeat (6) @(negedge clk);
    rd(1'b0, v); check("R11 one-shot result held", v, 8'h0C);

    // R10 falling polarity
    @(negedge clk); ext_pin = 1'b1; repeat (5) @(negedge clk);
    wr(1'b1, 8'h80); wr(1'b0, 8'h00); wr(1'b1, 8'h90);
    pin_pulse(1'b0, 7); repeat (6) @(negedge clk);
    rd(1'b0, v); check("R10 low width", v, 8'h07);
    rd(1'b1, v); check("R11 run auto clear low", v, 8'h80);

    // R12 overflow during measurement
    @(negedge clk); ext_pin = 1'b0; repeat (5) @(negedge clk);
    wr(1'b1, 8'h88); wr(1'b0, 8'hFE); wr(1'b1, 8'h98); wr(1'b0, 8'hF0);
    o0 = ovf_seen; i0 = irq_seen;
    pin_pulse(1'b1, 5); repeat (6) @(negedge clk);
    rd(1'b0, v); check("R12 pulse overflow value", v, 8'hF3);
    check("R12 pulse overflow count", ovf_seen - o0, 1);
    check("R12 pulse irq count", irq_seen - i0, 1);
    tick_raw = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule